// File: doc/BRIEF.md
# Four-Lane Serial Word Receiver with Failsafe Output Policy

This block rebuilds a 28-bit parallel word from four serial data lanes and one framing lane. All five lanes arrive already resolved to logic levels. A sampling clock runs at seven times the word rate, and each of its rising edges samples one bit slot at the centre of that slot. The framing lane carries a fixed seven-slot shape. The block uses that shape to find where each word begins. It then gathers seven bits from every lane. A completed word is moved to the output register in one step, and a regenerated word clock with 50% duty goes with it. The rising edge of that word clock is the strobe for the word.

Three cases have fixed output rules. First, an active-low powerdown input forces the word and the word clock low. Second, when the data lanes sit high while the framing lane keeps toggling, the output word is all ones. Third, when the framing lane stops toggling, the block declares the clock lost. The output word then keeps its last accepted value, and the word clock is held high.

Top module: `serial_word_rx`

## Requirements
- R1: Bit slots are numbered 0 to 6 in arrival order, and slot 0 comes first. The bit that lane L carries in slot S appears on `word_o[7*L+S]`. The whole word appears on `word_o` at the sampling edge of slot 6, and not earlier.
- R2: Across slots 0..6 the framing lane carries 1,1,0,0,0,1,1. A 0-to-1 change between two consecutive samples of the framing lane marks the sample just taken as slot 5. This realigns the slot count. A word whose slots slipped is dropped, and the next aligned word is accepted.
- R3: While `pd_n` is low, `word_o` is all zeros and `wclk_o` is low, at once and without waiting for a clock edge. The word register is cleared. After `pd_n` returns high, `word_o` stays zero until a new word is accepted.
- R4: When every data lane is high in every slot and the framing lane keeps its shape, `word_o` is all ones.
- R5: When the framing lane has not changed for more than 14 sampling ticks, the clock is declared lost. No word is accepted after that, and `word_o` holds the last accepted word.
- R6: While the clock is lost, `wclk_o` is high. This holds whether the framing lane is stuck high, as it is when floating, or stuck low.
- R7: In steady operation `wclk_o` is high for 3.5 sampling ticks and low for 3.5 ticks. It rises half a tick after the slot 2 edge and falls at the slot 6 edge. `word_o` does not change while `wclk_o` is high.
- R8: If any framing-lane sample in slots 0..6 differs from the expected shape, the word is dropped and the previous word stays. An accepted word replaces all 28 output bits at the same edge.
- R9: After reset, `word_o` is zero and `wclk_o` is high, because the clock counts as lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Sampling clock, one rising edge per bit slot |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_n | input | 1 | Powerdown, active low |
| din | input | 4 | Serial data lanes, one bit per lane per slot |
| cin | input | 1 | Framing lane |
| word_o | output | 28 | Rebuilt word |
| wclk_o | output | 1 | Regenerated word clock; its rising edge is the strobe |

## Verification
The hardest state to reach from the ports is a stopped framing lane, because the output must then hold while the data lanes keep changing. The stimulus holds the framing lane high, and later low, for longer than the loss threshold while it drives new data values on every tick. It also checks that the block recovers on the next well-formed word. A second hard case is loss of alignment. To reach it, the bench inserts extra slots ahead of a word and flips single framing-lane samples, then checks that the damaged word is dropped and the next one is taken.

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
  parameter int LANES = 4,
  parameter int BITS = 7,
  parameter logic [BITS-1:0] FRAME = 7'b1100011,
  parameter int RISE_SLOT = 5,
  parameter int LOSS_TICKS = 14
) (
  input  logic                   smp_clk,
  input  logic                   rst_n,
  input  logic                   pd_n,
  input  logic [LANES-1:0]       din,
  input  logic                   cin,
  output logic [LANES*BITS-1:0]  word_o,
  output logic                   wclk_o
);
  localparam int WORD = LANES * BITS;
  localparam int SW = $clog2(BITS);
  localparam int LAST = BITS - 1;
  localparam int HI_LEN = (BITS + 1) / 2;
  localparam int HI_FIRST = LAST - HI_LEN;
  localparam int SAT = LOSS_TICKS + 1;
  localparam int CW = $clog2(SAT + 1);

  logic [SW-1:0]   sl, cur;
  logic            prev_c, match, eq, rise, full, lost;
  logic [WORD-1:0] acc, nxt, word_q;
  logic [CW-1:0]   idle_cnt;
  logic            q_p, q_n;

  assign rise = !prev_c && cin;
  assign cur  = rise ? SW'(RISE_SLOT) : sl;
  assign eq   = (cin == FRAME[cur]);
  assign full = match && eq && (cur == SW'(LAST));
  assign lost = (idle_cnt == CW'(SAT));

  always_comb begin
    nxt = acc;
    for (int l = 0; l < LANES; l++)
      nxt[l*BITS + int'(cur)] = din[l];
  end

  always_ff @(posedge smp_clk or negedge rst_n) begin
    if (!rst_n) begin
      sl       <= '0;
      prev_c   <= 1'b1;
      match    <= 1'b0;
      acc      <= '0;
      word_q   <= '0;
      idle_cnt <= CW'(SAT);
      q_p      <= 1'b1;
    end else begin
      sl     <= (cur == SW'(LAST)) ? '0 : cur + 1'b1;
      prev_c <= cin;
      match  <= (cur == '0) ? eq : (match && eq);
      acc    <= nxt;
      if (!pd_n)     word_q <= '0;
      else if (full) word_q <= nxt;
      if (cin != prev_c) idle_cnt <= '0;
      else if (!lost)    idle_cnt <= idle_cnt + 1'b1;
      q_p <= lost || (cur >= SW'(HI_FIRST) && cur < SW'(LAST));
    end
  end

  always_ff @(negedge smp_clk or negedge rst_n) begin
    if (!rst_n) q_n <= 1'b1;
    else        q_n <= q_p;
  end

  assign word_o = word_q & {WORD{pd_n}};
  assign wclk_o = pd_n & q_p & q_n;
endmodule

// File: rtl/serial_word_rx_chk.sv
module serial_word_rx_chk #(
  parameter int WORD = 28,
  parameter int SAT = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pd_n,
  input logic            cin,
  input logic [WORD-1:0] word_o,
  input logic            wclk_o
);
  localparam int CW = $clog2(SAT + 1);
  logic [CW-1:0] ccnt;
  logic          cprev;
  logic          dead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt  <= CW'(SAT);
      cprev <= 1'b1;
    end else begin
      cprev <= cin;
      if (cin != cprev)          ccnt <= '0;
      else if (ccnt != CW'(SAT)) ccnt <= ccnt + 1'b1;
    end
  end
  assign dead = (ccnt == CW'(SAT));

  p_pd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> (word_o == '0 && !wclk_o));

  p_hold_lost_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dead && $past(dead) && pd_n && $past(pd_n)) |-> $stable(word_o));

  p_wclk_lost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dead && $past(dead) && pd_n) |-> wclk_o);

  p_strobe_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && $past(pd_n) && wclk_o && $past(wclk_o)) |-> $stable(word_o));
endmodule

bind serial_word_rx serial_word_rx_chk #(.WORD(LANES*BITS), .SAT(LOSS_TICKS+1)) u_chk (
  .clk(smp_clk), .rst_n(rst_n), .pd_n(pd_n), .cin(cin), .word_o(word_o), .wclk_o(wclk_o)
);

// File: tb/serial_word_rx_tb.sv
`timescale 1ns/1ps
module serial_word_rx_tb;
  localparam logic [6:0] FR = 7'b1100011;
  logic        clk = 1'b0, rst_n = 1'b0, pd_n = 1'b1, cin = 1'b1;
  logic [3:0]  din = '0;
  logic [27:0] word_o;
  logic        wclk_o;
  int          n_chk = 0, n_bad = 0;
  logic [27:0] exp_w = '0;
  logic [31:0] rs = 32'h2468ace1;

  always #4 clk = ~clk;

  serial_word_rx u_dut (.smp_clk(clk), .rst_n(rst_n), .pd_n(pd_n), .din(din), .cin(cin),
                        .word_o(word_o), .wclk_o(wclk_o));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    rs = rs * 32'd1664525 + 32'd1013904223;
    return rs;
  endfunction

  task automatic send(input logic [27:0] w, input logic [6:0] cp, input bit upd,
                      input int exp_hi, input string tag);
    int hi = 0;
    bit mid = 1'b1;
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      for (int l = 0; l < 4; l++) din[l] = w[l*7+s];
      cin = cp[s];
      #1 hi += int'(wclk_o);
      @(posedge clk);
      #1 hi += int'(wclk_o);
      if (s < 6 && word_o !== exp_w) mid = 1'b0;
    end
    if (upd) exp_w = w;
    chk(mid, {tag, " held before slot 6 (R8)"}, 32'(mid), 32'd1);
    chk(word_o === exp_w, tag, 32'(word_o), 32'(exp_w));
    if (exp_hi >= 0) chk(hi == exp_hi, {tag, " word clock high half-ticks (R7)"}, hi, exp_hi);
  endtask

  task automatic stall(input int n, input logic cv, input string tag);
    bit hold_ok = 1'b1, wclk_ok = 1'b1;
    for (int t = 1; t <= n; t++) begin
      @(negedge clk);
      din = rnd()[3:0];
      cin = cv;
      #1 if (t >= 19 && wclk_o !== 1'b1) wclk_ok = 1'b0;
      @(posedge clk);
      #1 if (t >= 19 && wclk_o !== 1'b1) wclk_ok = 1'b0;
      if (word_o !== exp_w) hold_ok = 1'b0;
    end
    chk(hold_ok, {"R5 hold while lost ", tag}, 32'(word_o), 32'(exp_w));
    chk(wclk_ok, {"R6 word clock high while lost ", tag}, 32'(wclk_ok), 32'd1);
  endtask

  task automatic slip(input int n, input logic cv);
    bit ok = 1'b1;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      din = rnd()[3:0];
      cin = cv;
      @(posedge clk);
      #1 if (word_o !== exp_w) ok = 1'b0;
    end
    chk(ok, "R2 hold during slipped slots", 32'(word_o), 32'(exp_w));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(word_o === '0, "R9 reset word", 32'(word_o), 32'd0);
    chk(wclk_o === 1'b1, "R9 reset word clock high", 32'(wclk_o), 32'd1);

    send('0, FR, 1'b1, -1, "R1 prime");
    for (int b = 0; b < 28; b++) send(28'd1 << b, FR, 1'b1, 7, "R1 walking one");
    for (int b = 0; b < 28; b++) send(~(28'd1 << b), FR, 1'b1, 7, "R1 walking zero");
    for (int i = 1; i <= 20; i++) send(28'(i * 32'h09E3779B ^ (i << 13)), FR, 1'b1, 7, "R1 mixed pattern");
    send('1, FR, 1'b1, 7, "R4 idle-high lanes");
    send('1, FR, 1'b1, 7, "R4 idle-high lanes repeat");

    send(28'h5A5A5A5, FR, 1'b1, 7, "R1 before slip");
    slip(2, 1'b1);
    send(28'h0F0F0F0, FR, 1'b0, -1, "R2 slipped word dropped");
    send(28'h3C3C3C3, FR, 1'b1, -1, "R2 realigned word");
    slip(4, 1'b0);
    send(28'h1111111, FR, 1'b0, -1, "R2 slipped word dropped");
    send(28'h2222222, FR, 1'b1, -1, "R2 realigned word");

    send(28'hABCDEF1, FR ^ 7'b0000001, 1'b0, -1, "R8 slot 0 corrupt");
    send(28'h7654321, FR, 1'b1, -1, "R8 after corrupt");
    send(28'h0000FFF, FR ^ 7'b0001000, 1'b0, -1, "R8 slot 3 corrupt");
    send(28'hFFF0000, FR, 1'b1, 7, "R8 after corrupt");

    send(28'h9876543, FR, 1'b1, 7, "R5 last word before stall");
    stall(24, 1'b1, "stuck high");
    send(exp_w, FR, 1'b1, -1, "R5 resume prime");
    send(28'h1357913, FR, 1'b1, -1, "R5 resume after stuck high");
    stall(24, 1'b0, "stuck low");
    send(exp_w, FR, 1'b1, -1, "R5 resume prime");
    send(28'h2468ACE, FR, 1'b1, -1, "R5 resume after stuck low");

    @(negedge clk) pd_n = 1'b0;
    #1;
    chk(word_o === '0, "R3 immediate zero word", 32'(word_o), 32'd0);
    chk(wclk_o === 1'b0, "R3 immediate low word clock", 32'(wclk_o), 32'd0);
    exp_w = '0;
    send(28'hDEADBEE, FR, 1'b0, 0, "R3 powerdown word");
    send(28'hFFFFFFF, FR, 1'b0, 0, "R3 powerdown word");
    pd_n = 1'b1;
    #1 chk(word_o === '0, "R3 cleared after release", 32'(word_o), 32'd0);
    send('0, FR, 1'b1, -1, "R3 after release");
    send(28'hC0FFEE1, FR, 1'b1, -1, "R3 first word after release");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule